// File: doc/BRIEF.md
# Tag-based operand forwarding unit

This block schedules floating-point style arithmetic out of order by tracking dependences through station tags instead of register names. Instructions enter one per cycle and are placed in one of three adder stations or one of two multiplier stations. Each of the four architectural registers carries a busy flag and the tag of the station that will write it next. A source operand whose register is still waiting is recorded by that tag rather than by value.

An adder unit and a multiplier unit each serve their own stations. Each unit computes with a fixed latency and then offers its result on a single shared result bus, together with the tag of the station that produced it. Every waiting station operand and every register still expecting that tag takes the value in the same edge. Six operand buffers, filled through a write port, supply constant operands and register loads. The arithmetic is plain modular integer add and multiply, standing in for the real datapaths.

Top module: `tagfwd_core`

## Requirements
- R1: After reset no register is busy, every register value is 0, the result bus is idle and `issue_ready` is high for every opcode.
- R2: Tag codes: 0 means no tag, buffer i owns tag 1+i, multiplier station j owns tag 8+j, adder station k owns tag 10+k. An accepted add (op 0) or multiply (op 1) takes the lowest-numbered free station of its kind. From the next cycle its destination register is busy with that station's tag.
- R3: When a source register is busy at issue, the station records that register's tag. A following instruction that writes the same register replaces the register's tag with its own station's tag. The final value is the in-order result.
- R4: A result on the bus is taken by every station operand waiting on its tag. After all work drains, the registers equal those of strict in-order execution of the same stream.
- R5: A register whose tag matches the bus tag takes the value and clears its busy flag. A register whose tag has been replaced meanwhile keeps its value.
- R6: Op 2 copies buffer `issue_b_idx` into the destination register at once and clears its busy flag and tag. It never stalls.
- R7: A unit starts a station only when both operands are present. With no contention, an add whose operands are ready at issue is on the bus ADD_LAT+1 edges after the issue edge, and a multiply likewise after MUL_LAT+1 edges.
- R8: At most one result is on the bus per cycle. The adder wins when both units finish together, and the multiplier holds its result and tag and drives the bus in the next free cycle.
- R9: `issue_ready` is low for an add or multiply only when every station of that kind is busy.
- R10: Add and multiply results wrap modulo 2^DW.
- R11: Op 3 is accepted and changes no register value, busy flag or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Operand buffer write strobe |
| buf_widx | input | 3 | Operand buffer write index |
| buf_wdata | input | DW | Operand buffer write data |
| issue_valid | input | 1 | Instruction offered |
| issue_op | input | 2 | 0 add, 1 multiply, 2 load from buffer, 3 no operation |
| issue_dst | input | 2 | Destination register |
| issue_rs | input | 2 | Register supplying the first operand |
| issue_b_is_buf | input | 1 | Second operand from a buffer (1) or a register (0) |
| issue_b_idx | input | 3 | Buffer or register index of the second operand |
| issue_ready | output | 1 | Instruction accepted when valid |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TW | Tag of the producing station |
| cdb_data | output | DW | Result value |
| reg_busy | output | NREG | Register busy flags |
| reg_tag | output | NREG*TW | Register tags, register i at bits i*TW |
| reg_val | output | NREG*DW | Register values, register i at bits i*DW |

## Verification
The bench builds the block with its default parameters: 16-bit data, four registers, six buffers, three adder and two multiplier stations, adder latency 2 and multiplier latency 3. With that configuration, every combination of opcode, destination, first source and second-operand source fits in one long stream of 320 instructions. That stream produces dense chains of read-after-write, write-after-write and write-after-read hazards, and the result is compared against an in-order arithmetic model. The one-cycle gap between the two latencies lets a multiply issued one cycle before an add finish together with it, so arbitration and the held result become reachable. A short chain behind a slow multiply fills all adder stations to reach the stall.

// File: rtl/tagfwd_pkg.sv
package tagfwd_pkg;

   typedef enum logic [1:0] {
      OPC_ADD  = 2'd0,
      OPC_MUL  = 2'd1,
      OPC_LOAD = 2'd2,
      OPC_NONE = 2'd3
   } opc_e;

   typedef enum logic {
      UNIT_ADD = 1'b0,
      UNIT_MUL = 1'b1
   } unit_kind_e;

endpackage

// File: rtl/tagfwd_station_bank.sv
module tagfwd_station_bank #(
   parameter int N    = 3,
   parameter int DW   = 16,
   parameter int TW   = 4,
   parameter int TAG0 = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_a_rdy,
   input  logic [TW-1:0] wr_a_tag,
   input  logic [DW-1:0] wr_a_val,
   input  logic          wr_b_rdy,
   input  logic [TW-1:0] wr_b_tag,
   input  logic [DW-1:0] wr_b_val,
   input  logic          bus_valid,
   input  logic [TW-1:0] bus_tag,
   input  logic [DW-1:0] bus_data,
   input  logic          release_en,
   input  logic [TW-1:0] release_tag,
   output logic          free_any,
   output logic [TW-1:0] free_tag,
   output logic          rdy_any,
   output logic [TW-1:0] rdy_tag,
   output logic [DW-1:0] rdy_a,
   output logic [DW-1:0] rdy_b
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic          busy_q  [N];
   logic          a_rdy_q [N];
   logic          b_rdy_q [N];
   logic [TW-1:0] a_tag_q [N];
   logic [TW-1:0] b_tag_q [N];
   logic [DW-1:0] a_val_q [N];
   logic [DW-1:0] b_val_q [N];
   logic [IW-1:0] free_idx;
   logic [IW-1:0] rdy_idx;

   // lowest-numbered free station receives the next instruction
   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (!busy_q[k]) begin
            free_any = 1'b1;
            free_idx = IW'(k);
         end
      end
   end

   // lowest-numbered station with both operands present goes first
   always_comb begin
      rdy_any = 1'b0;
      rdy_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (busy_q[k] && a_rdy_q[k] && b_rdy_q[k]) begin
            rdy_any = 1'b1;
            rdy_idx = IW'(k);
         end
      end
   end

   assign free_tag = TW'(TAG0) + TW'(free_idx);
   assign rdy_tag  = TW'(TAG0) + TW'(rdy_idx);
   assign rdy_a    = a_val_q[rdy_idx];
   assign rdy_b    = b_val_q[rdy_idx];

   for (genvar k = 0; k < N; k++) begin : g_st
      localparam logic [TW-1:0] MY_TAG = TW'(TAG0 + k);
      logic take_wr, take_rel, a_hit, b_hit;

      assign take_wr  = wr_en && (free_idx == IW'(k));
      assign take_rel = release_en && (release_tag == MY_TAG);
      assign a_hit    = bus_valid && busy_q[k] && !a_rdy_q[k] && (a_tag_q[k] == bus_tag);
      assign b_hit    = bus_valid && busy_q[k] && !b_rdy_q[k] && (b_tag_q[k] == bus_tag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q[k]  <= 1'b0;
            a_rdy_q[k] <= 1'b0;
            b_rdy_q[k] <= 1'b0;
            a_tag_q[k] <= '0;
            b_tag_q[k] <= '0;
            a_val_q[k] <= '0;
            b_val_q[k] <= '0;
         end else begin
            if (take_rel) busy_q[k] <= 1'b0;
            if (a_hit) begin
               a_rdy_q[k] <= 1'b1;
               a_val_q[k] <= bus_data;
            end
            if (b_hit) begin
               b_rdy_q[k] <= 1'b1;
               b_val_q[k] <= bus_data;
            end
            if (take_wr) begin
               busy_q[k]  <= 1'b1;
               a_rdy_q[k] <= wr_a_rdy;
               a_tag_q[k] <= wr_a_tag;
               a_val_q[k] <= wr_a_val;
               b_rdy_q[k] <= wr_b_rdy;
               b_tag_q[k] <= wr_b_tag;
               b_val_q[k] <= wr_b_val;
            end
         end
      end
   end

endmodule

// File: rtl/tagfwd_exec_unit.sv
module tagfwd_exec_unit
   import tagfwd_pkg::*;
#(
   parameter unit_kind_e KIND = UNIT_ADD,
   parameter int         DW   = 16,
   parameter int         TW   = 4,
   parameter int         LAT  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic [TW-1:0] tag_in,
   input  logic          grant,
   output logic          busy,
   output logic          req,
   output logic [DW-1:0] res,
   output logic [TW-1:0] tag
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] fn;

   if (KIND == UNIT_MUL) begin : g_mul
      assign fn = op_a * op_b;
   end else begin : g_add
      assign fn = op_a + op_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         res   <= '0;
         tag   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(LAT - 1);
            res   <= fn;
            tag   <= tag_in;
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (grant) begin
         busy <= 1'b0;
      end
   end

   assign req = busy && (cnt_q == '0);

endmodule

// File: rtl/tagfwd_regfile.sv
module tagfwd_regfile #(
   parameter int NREG = 4,
   parameter int DW   = 16,
   parameter int TW   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic [TW-1:0]        bus_tag,
   input  logic [DW-1:0]        bus_data,
   input  logic [$clog2(NREG)-1:0] wr_idx,
   input  logic                 tag_en,
   input  logic [TW-1:0]        tag_val,
   input  logic                 ld_en,
   input  logic [DW-1:0]        ld_val,
   output logic [NREG-1:0]      busy_o,
   output logic [NREG*TW-1:0]   tag_o,
   output logic [NREG*DW-1:0]   val_o
);
   localparam int RIW = $clog2(NREG);

   logic          busy_q [NREG];
   logic [TW-1:0] tag_q  [NREG];
   logic [DW-1:0] val_q  [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic sel;
      assign sel = (wr_idx == RIW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q[g] <= 1'b0;
            tag_q[g]  <= '0;
            val_q[g]  <= '0;
         end else begin
            if (bus_valid && busy_q[g] && (tag_q[g] == bus_tag)) begin
               val_q[g]  <= bus_data;
               busy_q[g] <= 1'b0;
               tag_q[g]  <= '0;
            end
            if (tag_en && sel) begin
               busy_q[g] <= 1'b1;
               tag_q[g]  <= tag_val;
            end
            if (ld_en && sel) begin
               val_q[g]  <= ld_val;
               busy_q[g] <= 1'b0;
               tag_q[g]  <= '0;
            end
         end
      end

      assign busy_o[g]         = busy_q[g];
      assign tag_o[g*TW +: TW] = tag_q[g];
      assign val_o[g*DW +: DW] = val_q[g];
   end

endmodule

// File: rtl/tagfwd_core.sv
module tagfwd_core
   import tagfwd_pkg::*;
#(
   parameter int DW       = 16,
   parameter int TW       = 4,
   parameter int NREG     = 4,
   parameter int NBUF     = 6,
   parameter int NADD     = 3,
   parameter int NMUL     = 2,
   parameter int ADD_LAT  = 2,
   parameter int MUL_LAT  = 3,
   parameter int MUL_TAG0 = 8,
   parameter int ADD_TAG0 = 10,
   localparam int RIW     = $clog2(NREG),
   localparam int BIW     = $clog2(NBUF),
   localparam int SW      = (BIW > RIW) ? BIW : RIW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               buf_we,
   input  logic [BIW-1:0]     buf_widx,
   input  logic [DW-1:0]      buf_wdata,
   input  logic               issue_valid,
   input  logic [1:0]         issue_op,
   input  logic [RIW-1:0]     issue_dst,
   input  logic [RIW-1:0]     issue_rs,
   input  logic               issue_b_is_buf,
   input  logic [SW-1:0]      issue_b_idx,
   output logic               issue_ready,
   output logic               cdb_valid,
   output logic [TW-1:0]      cdb_tag,
   output logic [DW-1:0]      cdb_data,
   output logic [NREG-1:0]    reg_busy,
   output logic [NREG*TW-1:0] reg_tag,
   output logic [NREG*DW-1:0] reg_val
);
   // elaboration-time checks on the tag plan and latencies
   if (NBUF + 1 > MUL_TAG0) begin : g_bad_buf_tags
      $error("buffer tags overlap multiplier station tags");
   end
   if (MUL_TAG0 + NMUL > ADD_TAG0) begin : g_bad_mul_tags
      $error("multiplier station tags overlap adder station tags");
   end
   if (ADD_TAG0 + NADD > (1 << TW)) begin : g_bad_add_tags
      $error("adder station tags exceed the tag width");
   end
   if (ADD_LAT < 1 || MUL_LAT < 1) begin : g_bad_lat
      $error("unit latency must be at least one cycle");
   end
   if (NREG < 2 || NBUF < 2) begin : g_bad_sizes
      $error("register file and buffer set need at least two entries");
   end

   logic [DW-1:0] bufs_q [NBUF];
   logic [TW-1:0] rtag [NREG];
   logic [DW-1:0] rval [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign rtag[g] = reg_tag[g*TW +: TW];
      assign rval[g] = reg_val[g*DW +: DW];
   end

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 bufs_q[g] <= '0;
         else if (buf_we && buf_widx == BIW'(g))     bufs_q[g] <= buf_wdata;
      end
   end

   // bus signals
   logic          add_req, mul_req, add_busy, mul_busy;
   logic          grant_add, grant_mul;
   logic [DW-1:0] add_res, mul_res;
   logic [TW-1:0] add_tag_q, mul_tag_q;

   assign grant_add = add_req;
   assign grant_mul = mul_req && !add_req;
   assign cdb_valid = add_req || mul_req;
   assign cdb_tag   = add_req ? add_tag_q : mul_tag_q;
   assign cdb_data  = add_req ? add_res   : mul_res;

   // operand resolution with same-cycle bus bypass
   logic [DW-1:0] buf_rd;
   logic          a_rdy, b_rdy;
   logic [TW-1:0] a_tag, b_tag;
   logic [DW-1:0] a_val, b_val;
   logic [RIW-1:0] rb;

   assign rb = issue_b_idx[RIW-1:0];

   always_comb begin
      buf_rd = '0;
      if (int'(issue_b_idx) < NBUF) buf_rd = bufs_q[issue_b_idx];
   end

   always_comb begin
      a_rdy = 1'b1;
      a_tag = '0;
      a_val = rval[issue_rs];
      if (reg_busy[issue_rs]) begin
         if (cdb_valid && cdb_tag == rtag[issue_rs]) begin
            a_val = cdb_data;
         end else begin
            a_rdy = 1'b0;
            a_tag = rtag[issue_rs];
            a_val = '0;
         end
      end
   end

   always_comb begin
      b_rdy = 1'b1;
      b_tag = '0;
      if (issue_b_is_buf) begin
         b_val = buf_rd;
      end else begin
         b_val = rval[rb];
         if (reg_busy[rb]) begin
            if (cdb_valid && cdb_tag == rtag[rb]) begin
               b_val = cdb_data;
            end else begin
               b_rdy = 1'b0;
               b_tag = rtag[rb];
               b_val = '0;
            end
         end
      end
   end

   // issue control
   logic          add_free, mul_free, accept;
   logic          add_wr, mul_wr, ld_wr;
   logic [TW-1:0] add_free_tag, mul_free_tag;

   always_comb begin
      unique case (opc_e'(issue_op))
         OPC_ADD: issue_ready = add_free;
         OPC_MUL: issue_ready = mul_free;
         default: issue_ready = 1'b1;
      endcase
   end

   assign accept = issue_valid && issue_ready;
   assign add_wr = accept && (opc_e'(issue_op) == OPC_ADD);
   assign mul_wr = accept && (opc_e'(issue_op) == OPC_MUL);
   assign ld_wr  = accept && (opc_e'(issue_op) == OPC_LOAD);

   // station banks
   logic          add_rdy_any, mul_rdy_any;
   logic [TW-1:0] add_rdy_tag, mul_rdy_tag;
   logic [DW-1:0] add_ra, add_rb, mul_ra, mul_rb;

   tagfwd_station_bank #(.N(NADD), .DW(DW), .TW(TW), .TAG0(ADD_TAG0)) i_add_bank (
      .clk, .rst_n,
      .wr_en(add_wr),
      .wr_a_rdy(a_rdy), .wr_a_tag(a_tag), .wr_a_val(a_val),
      .wr_b_rdy(b_rdy), .wr_b_tag(b_tag), .wr_b_val(b_val),
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
      .release_en(grant_add), .release_tag(add_tag_q),
      .free_any(add_free), .free_tag(add_free_tag),
      .rdy_any(add_rdy_any), .rdy_tag(add_rdy_tag), .rdy_a(add_ra), .rdy_b(add_rb)
   );

   tagfwd_station_bank #(.N(NMUL), .DW(DW), .TW(TW), .TAG0(MUL_TAG0)) i_mul_bank (
      .clk, .rst_n,
      .wr_en(mul_wr),
      .wr_a_rdy(a_rdy), .wr_a_tag(a_tag), .wr_a_val(a_val),
      .wr_b_rdy(b_rdy), .wr_b_tag(b_tag), .wr_b_val(b_val),
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
      .release_en(grant_mul), .release_tag(mul_tag_q),
      .free_any(mul_free), .free_tag(mul_free_tag),
      .rdy_any(mul_rdy_any), .rdy_tag(mul_rdy_tag), .rdy_a(mul_ra), .rdy_b(mul_rb)
   );

   // execution units
   tagfwd_exec_unit #(.KIND(UNIT_ADD), .DW(DW), .TW(TW), .LAT(ADD_LAT)) i_add_unit (
      .clk, .rst_n,
      .start(!add_busy && add_rdy_any),
      .op_a(add_ra), .op_b(add_rb), .tag_in(add_rdy_tag),
      .grant(grant_add),
      .busy(add_busy), .req(add_req), .res(add_res), .tag(add_tag_q)
   );

   tagfwd_exec_unit #(.KIND(UNIT_MUL), .DW(DW), .TW(TW), .LAT(MUL_LAT)) i_mul_unit (
      .clk, .rst_n,
      .start(!mul_busy && mul_rdy_any),
      .op_a(mul_ra), .op_b(mul_rb), .tag_in(mul_rdy_tag),
      .grant(grant_mul),
      .busy(mul_busy), .req(mul_req), .res(mul_res), .tag(mul_tag_q)
   );

   // architectural registers
   tagfwd_regfile #(.NREG(NREG), .DW(DW), .TW(TW)) i_regs (
      .clk, .rst_n,
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
      .wr_idx(issue_dst),
      .tag_en(add_wr || mul_wr),
      .tag_val(add_wr ? add_free_tag : mul_free_tag),
      .ld_en(ld_wr), .ld_val(buf_rd),
      .busy_o(reg_busy), .tag_o(reg_tag), .val_o(reg_val)
   );

endmodule

// File: rtl/tagfwd_core_chk.sv
module tagfwd_core_chk
   import tagfwd_pkg::*;
#(
   parameter int TW       = 4,
   parameter int NREG     = 4,
   parameter int NADD     = 3,
   parameter int NMUL     = 2,
   parameter int DW       = 16,
   parameter int MUL_TAG0 = 8,
   parameter int ADD_TAG0 = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 issue_valid,
   input logic                 issue_ready,
   input logic [1:0]           issue_op,
   input logic [$clog2(NREG)-1:0] issue_dst,
   input logic [NREG-1:0]      reg_busy,
   input logic [NREG*TW-1:0]   reg_tag,
   input logic                 cdb_valid,
   input logic [TW-1:0]        cdb_tag,
   input logic                 add_req,
   input logic                 mul_req,
   input logic                 grant_mul,
   input logic [DW-1:0]        mul_res,
   input logic [TW-1:0]        mul_tag
);
   logic acc;
   assign acc = issue_valid && issue_ready;

   assert_issue_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (issue_op == OPC_ADD || issue_op == OPC_MUL) |=> reg_busy[$past(issue_dst)]);

   assert_add_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && issue_op == OPC_ADD |=> int'(reg_tag[$past(issue_dst)*TW +: TW]) >= ADD_TAG0);

   assert_mul_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && issue_op == OPC_MUL |=> int'(reg_tag[$past(issue_dst)*TW +: TW]) < ADD_TAG0);

   assert_load_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc && issue_op == OPC_LOAD |=> !reg_busy[$past(issue_dst)]);

   assert_adder_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      add_req && mul_req |-> cdb_valid && int'(cdb_tag) >= ADD_TAG0);

   assert_mul_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mul_req && !grant_mul |=> mul_req && $stable(mul_res) && $stable(mul_tag));

   assert_stall_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_ready |-> (issue_op == OPC_ADD || issue_op == OPC_MUL));

   for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
      assert_busy_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
         reg_busy[g] |-> int'(reg_tag[g*TW +: TW]) >= MUL_TAG0
                      && int'(reg_tag[g*TW +: TW]) < ADD_TAG0 + NADD);

      assert_reg_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cdb_valid && reg_busy[g] && reg_tag[g*TW +: TW] == cdb_tag
         && !(acc && int'(issue_dst) == g && issue_op != OPC_NONE) |=> !reg_busy[g]);
   end

   initial begin
      assert_mul_range_R2: assert (MUL_TAG0 + NMUL <= ADD_TAG0);
   end

endmodule

bind tagfwd_core tagfwd_core_chk #(
   .TW(TW), .NREG(NREG), .NADD(NADD), .NMUL(NMUL), .DW(DW),
   .MUL_TAG0(MUL_TAG0), .ADD_TAG0(ADD_TAG0)
) i_chk (
   .clk(clk), .rst_n(rst_n),
   .issue_valid(issue_valid), .issue_ready(issue_ready),
   .issue_op(issue_op), .issue_dst(issue_dst),
   .reg_busy(reg_busy), .reg_tag(reg_tag),
   .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
   .add_req(add_req), .mul_req(mul_req), .grant_mul(grant_mul),
   .mul_res(mul_res), .mul_tag(mul_tag_q)
);

// File: tb/test_tagfwd_core.sv
module test_tagfwd_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        buf_we = 1'b0;
   logic [2:0]  buf_widx = '0;
   logic [15:0] buf_wdata = '0;
   logic        issue_valid = 1'b0;
   logic [1:0]  issue_op = '0;
   logic [1:0]  issue_dst = '0;
   logic [1:0]  issue_rs = '0;
   logic        issue_b_is_buf = 1'b0;
   logic [2:0]  issue_b_idx = '0;
   logic        issue_ready;
   logic        cdb_valid;
   logic [3:0]  cdb_tag;
   logic [15:0] cdb_data;
   logic [3:0]  reg_busy;
   logic [15:0] reg_tag;
   logic [63:0] reg_val;

   tagfwd_core i_tagfwd_core (
      .clk, .rst_n, .buf_we, .buf_widx, .buf_wdata,
      .issue_valid, .issue_op, .issue_dst, .issue_rs, .issue_b_is_buf, .issue_b_idx,
      .issue_ready, .cdb_valid, .cdb_tag, .cdb_data,
      .reg_busy, .reg_tag, .reg_val
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int cyc = 0;
   int log_n = 0;
   int log_tag [8];
   int log_cyc [8];

   logic [15:0] m_reg [4];
   logic [15:0] m_buf [6];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && cdb_valid && log_n < 8) begin
         log_tag[log_n] = int'(cdb_tag);
         log_cyc[log_n] = cyc;
         log_n = log_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_buf(input int idx, input logic [15:0] v);
      buf_we = 1'b1;
      buf_widx = 3'(idx);
      buf_wdata = v;
      @(posedge clk);
      @(negedge clk);
      buf_we = 1'b0;
      m_buf[idx] = v;
   endtask

   task automatic issue(input logic [1:0] op, input int dst, input int rs,
                        input bit bb, input int bi);
      logic [15:0] bv;
      issue_valid = 1'b1;
      issue_op = op;
      issue_dst = 2'(dst);
      issue_rs = 2'(rs);
      issue_b_is_buf = bb;
      issue_b_idx = 3'(bi);
      #1;
      while (!issue_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      bv = bb ? m_buf[bi] : m_reg[bi];
      case (op)
         2'd0: m_reg[dst] = m_reg[rs] + bv;
         2'd1: m_reg[dst] = m_reg[rs] * bv;
         2'd2: m_reg[dst] = m_buf[bi];
         default: ;
      endcase
   endtask

   task automatic drain();
      while (reg_busy != 4'b0) @(negedge clk);
      repeat (30) @(negedge clk);
   endtask

   task automatic cmp_regs(input string req);
      for (int i = 0; i < 4; i++)
         check(reg_val[i*16 +: 16] == m_reg[i], req, reg_val[i*16 +: 16], m_reg[i]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int c0;
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      for (int i = 0; i < 6; i++) m_buf[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      check(reg_busy == 4'b0, "R1 busy", reg_busy, 0);
      check(reg_val == 64'b0, "R1 values", reg_val[15:0], 0);
      check(!cdb_valid, "R1 bus idle", cdb_valid, 0);
      for (int op = 0; op < 4; op++) begin
         issue_op = 2'(op);
         #1;
         check(issue_ready, "R1 ready", issue_ready, 1);
      end
      @(negedge clk);

      for (int i = 0; i < 6; i++) wr_buf(i, 16'(3 + 4 * i));
      for (int r = 0; r < 4; r++) issue(2'd2, r, 0, 1'b1, r);
      // R6 load value, not busy
      check(reg_busy == 4'b0, "R6 load not busy", reg_busy, 0);
      cmp_regs("R6 load value");

      // R2/R3 tag assignment and relinking
      issue(2'd0, 1, 1, 1'b1, 0);
      check(reg_busy[1] == 1'b1, "R2 add busy", reg_busy[1], 1);
      check(reg_tag[7:4] == 4'd10, "R2 add tag", reg_tag[7:4], 10);
      issue(2'd1, 1, 1, 1'b1, 1);
      check(reg_tag[7:4] == 4'd8, "R3 relinked tag", reg_tag[7:4], 8);
      drain();
      check(reg_val[31:16] == m_reg[1], "R3 chained value", reg_val[31:16], m_reg[1]);

      // R5 stale tag ignored, R6 immediate load
      issue(2'd0, 0, 0, 1'b1, 2);
      issue(2'd2, 0, 0, 1'b1, 3);
      check(reg_busy[0] == 1'b0, "R6 load clears busy", reg_busy[0], 0);
      repeat (12) @(negedge clk);
      check(reg_val[15:0] == m_buf[3], "R5 stale broadcast ignored", reg_val[15:0], m_buf[3]);
      drain();

      // R11 op 3 has no effect
      issue(2'd3, 2, 1, 1'b0, 3);
      check(reg_busy == 4'b0, "R11 no busy", reg_busy, 0);
      cmp_regs("R11 values unchanged");

      // R9 stall with all adder stations waiting on a slow multiply
      issue(2'd1, 2, 0, 1'b1, 0);
      issue(2'd0, 3, 2, 1'b1, 1);
      issue(2'd0, 1, 2, 1'b1, 1);
      issue(2'd0, 0, 3, 1'b1, 2);
      issue_op = 2'd0;
      #1;
      check(!issue_ready, "R9 add stalls", issue_ready, 0);
      issue_op = 2'd1;
      #1;
      check(issue_ready, "R9 mul not stalled", issue_ready, 1);
      issue_op = 2'd2;
      #1;
      check(issue_ready, "R9 load never stalls", issue_ready, 1);
      drain();
      cmp_regs("R4 after stall");

      // R7/R8 latency and arbitration
      log_n = 0;
      issue(2'd1, 2, 0, 1'b1, 0);
      c0 = cyc;
      issue(2'd0, 3, 1, 1'b1, 1);
      repeat (8) @(negedge clk);
      check(log_n >= 2, "R8 two broadcasts", log_n, 2);
      check(log_tag[0] == 10, "R8 adder first", log_tag[0], 10);
      check(log_cyc[0] == c0 + 3, "R7 add latency", log_cyc[0], c0 + 3);
      check(log_tag[1] == 8, "R8 multiplier after", log_tag[1], 8);
      check(log_cyc[1] == c0 + 4, "R8 held one cycle", log_cyc[1], c0 + 4);
      drain();
      cmp_regs("R10 values after race");

      // R4/R10 sweep over all instruction shapes
      begin
         int k = 0;
         for (int op = 0; op < 2; op++)
            for (int d = 0; d < 4; d++)
               for (int s = 0; s < 4; s++)
                  for (int b = 0; b < 10; b++) begin
                     if (k % 16 == 0) begin
                        drain();
                        cmp_regs("R4 sweep");
                        for (int i = 0; i < 6; i++) wr_buf(i, 16'(k * 37 + i * 22 + 1001));
                        for (int r = 0; r < 4; r++) issue(2'd2, r, 0, 1'b1, 5 - r);
                        for (int i = 0; i < 6; i++) wr_buf(i, 16'(k * 13 + i * 58 + 211));
                     end
                     if (b < 4) issue(2'(op), d, s, 1'b0, b);
                     else       issue(2'(op), d, s, 1'b1, b - 4);
                     k++;
                  end
         drain();
         cmp_regs("R10 sweep final");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule